// File: doc/BRIEF.md
# Single-Wire Bus ROM Command Tracker

This block follows the network layer of a single-wire bus transaction. It consumes two one-cycle strobes from a link-level monitor: a bus-reset strobe, and a bit strobe that comes with the sampled bit value. After every bus reset it assembles the first byte as a ROM command and classifies it. It then takes one of three paths. It can capture the 64-bit device identifier directly. It can rebuild the identifier from search triplets. Or it can skip the identifier altogether. In all three cases the next byte on the bus is captured as the device function command.

The ROM command byte and its decoded class are held on level outputs. When an identifier has been captured it appears on `rom_id` with a one-cycle `rom_vld` pulse. During a search the per-position true bits and complement bits are exported as well, so that positions where both values were 0 (a collision) can be seen. The function command byte appears with a one-cycle `fn_vld` pulse and an unsupported-code flag. An unknown ROM command raises `rom_err` and parks the block until the next bus reset.

Top module: `owr_rom_decoder`

## Requirements
- R1: After `rst_n` is low, `rom_vld`, `fn_vld`, `rom_err` and `rom_type` are 0. Bit strobes are ignored until the first `reset_stb`, so `fn_cmd` stays 0 and no strobe fires.
- R2: A `reset_stb` abandons any transaction in progress and clears the counters, `rom_err` and `rom_type`. The next bit is taken as bit 0 of a new ROM command.
- R3: Bytes and identifiers are assembled least significant bit first: the n-th bit received in a field (counting from 0) is stored at bit n. `rom_cmd` shows the command byte.
- R4: `rom_type` encodes the command class: 0 none, 1 read (0x33 or 0x0F), 2 match (0x55), 3 search (0xF0), 4 skip (0xCC), 5 overdrive match (0x69), 6 overdrive skip (0x3C), 7 unknown (any other value).
- R5: After a read, match or overdrive-match command, the next 64 bits form `rom_id`. `rom_vld` pulses for one cycle, the cycle after the 64th bit strobe.
- R6: After a skip or overdrive-skip command, the next 8 bits are the function command. No `rom_vld` pulse occurs.
- R7: After a search command, each identifier position n takes three bits in this order: true bit into `srch_true[n]`, complement bit into `srch_cmpl[n]`, and direction bit into `rom_id[n]`. The position advances only after the direction bit. `rom_vld` pulses after the 64th triplet.
- R8: The 8 bits after the identifier (or after a skip command) form `fn_cmd`, with a one-cycle `fn_vld` pulse. `fn_unsup` is 0 for 0x48, 0x4E, 0xBE, 0xB8 and 0xB4, and 1 for any other value.
- R9: An unknown ROM command sets `rom_err`, which stays high until the next `reset_stb`. Until then no `rom_vld` or `fn_vld` pulse occurs.
- R10: Once the function command has been captured, further bits change neither `rom_cmd` nor `fn_cmd` and raise no strobe until the next `reset_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe: a bus bit was sampled |
| bit_val | input | 1 | Value of the sampled bus bit, valid with `bit_stb` |
| reset_stb | input | 1 | One-cycle strobe: a bus reset was seen |
| rom_cmd | output | 8 | Last ROM command byte |
| rom_type | output | 3 | Decoded ROM command class (R4 encoding) |
| rom_err | output | 1 | Unknown ROM command since the last bus reset |
| rom_id | output | 64 | Captured device identifier |
| srch_true | output | 64 | Search true bits, one per identifier position |
| srch_cmpl | output | 64 | Search complement bits, one per identifier position |
| rom_vld | output | 1 | One-cycle pulse: `rom_id` is complete |
| fn_cmd | output | 8 | Captured function command byte |
| fn_vld | output | 1 | One-cycle pulse: `fn_cmd` is complete |
| fn_unsup | output | 1 | Function command is not a recognized code |

## Verification
The assertions assume three things about the inputs: `bit_stb` and `reset_stb` last one cycle each, `bit_stb` is never raised while `rst_n` is low, and the upstream monitor delivers bits only after a bus reset has opened a transaction. The stimulus meets these conditions. Every bit and every reset is a single-cycle pulse with at least one idle cycle after it, both strobes stay low during reset, and each transaction opens with a bus-reset pulse. The only exception is the directed power-up case, which deliberately sends bits with no reset to show that they are ignored.

// File: rtl/owr_pkg.sv
// Shared types for the ROM command tracker.
// Assumes command bytes are 8 bits wide, as the opcodes are defined that way.
package owr_pkg;

    localparam int CMD_BITS = 8;

    // Command class; the encoding is visible on the rom_type port.
    typedef enum logic [2:0] {
        RT_NONE     = 3'd0,
        RT_READ     = 3'd1,
        RT_MATCH    = 3'd2,
        RT_SEARCH   = 3'd3,
        RT_SKIP     = 3'd4,
        RT_OD_MATCH = 3'd5,
        RT_OD_SKIP  = 3'd6,
        RT_UNKNOWN  = 3'd7
    } rom_kind_e;

    // Transaction phase.
    typedef enum logic [2:0] {
        PH_CMD,
        PH_ROM,
        PH_SRCH,
        PH_FUNC,
        PH_HALT
    } phase_e;

endpackage

// File: rtl/owr_bitpos_reg.sv
// Register whose individual bits are written by index: one bit per write enable.
// Assumes idx < W whenever we is high.
module owr_bitpos_reg #(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [$clog2(W)-1:0] idx,
    input  logic                 d,
    output logic [W-1:0]         q
);

    // One decoded write-enable per bit position.
    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[g] <= 1'b0;
            else if (we && idx == ($clog2(W))'(g))
                q[g] <= d;
        end
    end

    // R3: the written bit appears at its indexed position.
    a_r3_bit_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && we) |=> q[$past(idx)] == $past(d));

endmodule

// File: rtl/owr_rom_opcode.sv
// Classifies a ROM command byte into its command class. Purely combinational.
module owr_rom_opcode
    import owr_pkg::*;
(
    input  logic [CMD_BITS-1:0] op,
    output rom_kind_e           kind
);

    // Map each known opcode to its class; anything else is unknown.
    always_comb begin
        case (op)
            8'h33, 8'h0F: kind = RT_READ;
            8'h55:        kind = RT_MATCH;
            8'hF0:        kind = RT_SEARCH;
            8'hCC:        kind = RT_SKIP;
            8'h69:        kind = RT_OD_MATCH;
            8'h3C:        kind = RT_OD_SKIP;
            default:      kind = RT_UNKNOWN;
        endcase
    end

endmodule

// File: rtl/owr_fn_opcode.sv
// Flags whether a function command byte is one of the recognized codes.
module owr_fn_opcode
    import owr_pkg::*;
(
    input  logic [CMD_BITS-1:0] op,
    output logic                known
);

    // Membership test over the recognized function codes.
    always_comb begin
        case (op)
            8'h48, 8'h4E, 8'hBE, 8'hB8, 8'hB4: known = 1'b1;
            default:                           known = 1'b0;
        endcase
    end

endmodule

// File: rtl/owr_rom_decoder.sv
// Network-layer tracker for a single-wire bus.
// Takes bit and bus-reset strobes from a link monitor. After every bus reset it
// assembles the ROM command, captures the identifier (directly or from search
// triplets) and then the function command byte.
// Assumes one-cycle strobes and no strobe while rst_n is low.
module owr_rom_decoder
    import owr_pkg::*;
#(
    parameter int ROM_BITS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_stb,
    input  logic                bit_val,
    input  logic                reset_stb,
    output logic [7:0]          rom_cmd,
    output logic [2:0]          rom_type,
    output logic                rom_err,
    output logic [ROM_BITS-1:0] rom_id,
    output logic [ROM_BITS-1:0] srch_true,
    output logic [ROM_BITS-1:0] srch_cmpl,
    output logic                rom_vld,
    output logic [7:0]          fn_cmd,
    output logic                fn_vld,
    output logic                fn_unsup
);

    localparam int IW  = $clog2(ROM_BITS);
    localparam int CIW = $clog2(CMD_BITS);

    phase_e          phase;
    rom_kind_e       rtype_q;
    rom_kind_e       kind_next;
    logic [IW-1:0]   cnt;
    logic [1:0]      trip;
    logic            take;
    logic            last_byte_bit;
    logic            last_rom_bit;
    logic            fn_known;
    logic [CMD_BITS-1:0] cmd_full;
    logic [CMD_BITS-1:0] fn_full;
    logic            we_cmd, we_rom, we_tru, we_cmp, we_fn;

    assign take          = bit_stb && !reset_stb;
    assign last_byte_bit = cnt[CIW-1:0] == CIW'(CMD_BITS - 1);
    assign last_rom_bit  = cnt == IW'(ROM_BITS - 1);
    // The final bit of a byte is its MSB, so the complete byte is known early.
    assign cmd_full      = {bit_val, rom_cmd[CMD_BITS-2:0]};
    assign fn_full       = {bit_val, fn_cmd[CMD_BITS-2:0]};
    assign rom_type      = rtype_q;

    assign we_cmd = take && phase == PH_CMD;
    assign we_rom = take && (phase == PH_ROM || (phase == PH_SRCH && trip == 2'd2));
    assign we_tru = take && phase == PH_SRCH && trip == 2'd0;
    assign we_cmp = take && phase == PH_SRCH && trip == 2'd1;
    assign we_fn  = take && phase == PH_FUNC;

    owr_bitpos_reg #(.W(CMD_BITS)) i_cmd_reg (
        .clk(clk), .rst_n(rst_n), .we(we_cmd), .idx(cnt[CIW-1:0]), .d(bit_val), .q(rom_cmd));
    owr_bitpos_reg #(.W(ROM_BITS)) i_rom_reg (
        .clk(clk), .rst_n(rst_n), .we(we_rom), .idx(cnt), .d(bit_val), .q(rom_id));
    owr_bitpos_reg #(.W(ROM_BITS)) i_tru_reg (
        .clk(clk), .rst_n(rst_n), .we(we_tru), .idx(cnt), .d(bit_val), .q(srch_true));
    owr_bitpos_reg #(.W(ROM_BITS)) i_cmp_reg (
        .clk(clk), .rst_n(rst_n), .we(we_cmp), .idx(cnt), .d(bit_val), .q(srch_cmpl));
    owr_bitpos_reg #(.W(CMD_BITS)) i_fn_reg (
        .clk(clk), .rst_n(rst_n), .we(we_fn), .idx(cnt[CIW-1:0]), .d(bit_val), .q(fn_cmd));

    owr_rom_opcode i_rom_op (.op(cmd_full), .kind(kind_next));
    owr_fn_opcode  i_fn_op  (.op(fn_full),  .known(fn_known));

    // Phase sequencing, position counters and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_HALT;
            cnt      <= '0;
            trip     <= 2'd0;
            rtype_q  <= RT_NONE;
            rom_err  <= 1'b0;
            rom_vld  <= 1'b0;
            fn_vld   <= 1'b0;
            fn_unsup <= 1'b0;
        end else begin
            rom_vld <= 1'b0;
            fn_vld  <= 1'b0;
            if (reset_stb) begin
                phase    <= PH_CMD;
                cnt      <= '0;
                trip     <= 2'd0;
                rtype_q  <= RT_NONE;
                rom_err  <= 1'b0;
                fn_unsup <= 1'b0;
            end else if (bit_stb) begin
                case (phase)
                    PH_CMD: begin
                        if (last_byte_bit) begin
                            cnt     <= '0;
                            rtype_q <= kind_next;
                            case (kind_next)
                                RT_READ, RT_MATCH, RT_OD_MATCH: phase <= PH_ROM;
                                RT_SEARCH:                      phase <= PH_SRCH;
                                RT_SKIP, RT_OD_SKIP:            phase <= PH_FUNC;
                                default: begin
                                    rom_err <= 1'b1;
                                    phase   <= PH_HALT;
                                end
                            endcase
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_ROM: begin
                        if (last_rom_bit) begin
                            cnt     <= '0;
                            rom_vld <= 1'b1;
                            phase   <= PH_FUNC;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_SRCH: begin
                        if (trip == 2'd2) begin
                            trip <= 2'd0;
                            if (last_rom_bit) begin
                                cnt     <= '0;
                                rom_vld <= 1'b1;
                                phase   <= PH_FUNC;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end else begin
                            trip <= trip + 1'b1;
                        end
                    end
                    PH_FUNC: begin
                        if (last_byte_bit) begin
                            cnt      <= '0;
                            fn_vld   <= 1'b1;
                            fn_unsup <= !fn_known;
                            phase    <= PH_HALT;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: a bus reset leaves no strobe, no error and no command class behind.
    a_r2_bus_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && reset_stb) |=> (!rom_vld && !fn_vld && !rom_err && rom_type == 3'd0));

    // R5: an identifier only completes after a command that carries one.
    a_r5_rom_needs_rom_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        rom_vld |-> (rom_type == 3'd1 || rom_type == 3'd2 || rom_type == 3'd3 || rom_type == 3'd5));

    // R8: the two completion pulses never coincide, and each follows a bit strobe.
    a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_vld && fn_vld));
    a_r8_fn_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        fn_vld |-> $past(bit_stb));

    // R9: the error flag holds until a bus reset and blocks all strobes.
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && rom_err && !reset_stb) |=> rom_err);
    a_r9_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rom_err |-> (!rom_vld && !fn_vld));

    // R10: once parked, the captured bytes do not move without a bus reset.
    a_r10_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && phase == PH_HALT && !reset_stb) |=> ($stable(fn_cmd) && $stable(rom_cmd) && !fn_vld));

endmodule

// File: tb/test_owr_rom_decoder.sv
`timescale 1ns/1ps
module test_owr_rom_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_stb = 1'b0;
    logic        bit_val = 1'b0;
    logic        reset_stb = 1'b0;
    logic [7:0]  rom_cmd;
    logic [2:0]  rom_type;
    logic        rom_err;
    logic [63:0] rom_id;
    logic [63:0] srch_true;
    logic [63:0] srch_cmpl;
    logic        rom_vld;
    logic [7:0]  fn_cmd;
    logic        fn_vld;
    logic        fn_unsup;

    owr_rom_decoder #(.ROM_BITS(64)) i_owr_rom_decoder (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .reset_stb(reset_stb), .rom_cmd(rom_cmd), .rom_type(rom_type),
        .rom_err(rom_err), .rom_id(rom_id), .srch_true(srch_true),
        .srch_cmpl(srch_cmpl), .rom_vld(rom_vld), .fn_cmd(fn_cmd),
        .fn_vld(fn_vld), .fn_unsup(fn_unsup));

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int n_rv   = 0;
    int n_fv   = 0;

    // Count completion pulses, sampled 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (rom_vld) n_rv++;
        if (fn_vld)  n_fv++;
    end

    typedef struct packed {
        logic [7:0]  cmd;
        logic [63:0] rom;
        logic [7:0]  fn;
        logic [2:0]  typ;
        logic        unsup;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{8'h33, 64'h1122334455667788, 8'h48, 3'd1, 1'b0},
        '{8'h0F, 64'hA5A5_0F0F_C3C3_9696, 8'hBE, 3'd1, 1'b0},
        '{8'h55, 64'h8000_0000_0000_0001, 8'h4E, 3'd2, 1'b0},
        '{8'h69, 64'h0123_4567_89AB_CDEF, 8'hB8, 3'd5, 1'b0},
        '{8'hCC, 64'h0, 8'hB4, 3'd4, 1'b0},
        '{8'h3C, 64'h0, 8'h12, 3'd6, 1'b1},
        '{8'hF0, 64'hDEAD_BEEF_0BAD_F00D, 8'h44, 3'd3, 1'b1}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_stb = 1'b1;
        bit_val = b;
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
    endtask

    task automatic send_rom(input logic [63:0] v);
        for (int i = 0; i < 64; i++) send_bit(v[i]);
    endtask

    // Triplets per position; at coll_pos both the true and complement bits are 0.
    task automatic send_search(input logic [63:0] v, input int coll_pos);
        for (int i = 0; i < 64; i++) begin
            if (i == coll_pos) begin
                send_bit(1'b0);
                send_bit(1'b0);
            end else begin
                send_bit(v[i]);
                send_bit(~v[i]);
            end
            send_bit(v[i]);
        end
    endtask

    task automatic bus_reset();
        @(negedge clk);
        reset_stb = 1'b1;
        @(negedge clk);
        reset_stb = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int rv0;
        int fv0;
        logic [63:0] sv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        chk("R1 rom_vld", 64'(rom_vld), 64'd0);
        chk("R1 fn_vld", 64'(fn_vld), 64'd0);
        chk("R1 rom_err", 64'(rom_err), 64'd0);
        chk("R1 rom_type", 64'(rom_type), 64'd0);
        // R1: bits before the first bus reset are ignored.
        send_byte(8'hCC);
        send_byte(8'h48);
        chk("R1 no fn_vld before bus reset", 64'(n_fv), 64'd0);
        chk("R1 fn_cmd untouched", 64'(fn_cmd), 64'd0);
        chk("R1 rom_cmd untouched", 64'(rom_cmd), 64'd0);

        // Table-driven transactions.
        for (int k = 0; k < 7; k++) begin
            bus_reset();
            rv0 = n_rv;
            fv0 = n_fv;
            send_byte(VECS[k].cmd);
            chk("R3 rom_cmd", 64'(rom_cmd), 64'(VECS[k].cmd));
            chk("R4 rom_type", 64'(rom_type), 64'(VECS[k].typ));
            if (VECS[k].typ == 3'd3) begin
                send_search(VECS[k].rom, 99);
                chk("R7 rom_id from direction bits", rom_id, VECS[k].rom);
                chk("R7 srch_true", srch_true, VECS[k].rom);
                chk("R7 srch_cmpl", srch_cmpl, ~VECS[k].rom);
                chk("R7 one rom_vld", 64'(n_rv - rv0), 64'd1);
            end else if (VECS[k].typ == 3'd4 || VECS[k].typ == 3'd6) begin
                chk("R6 no rom_vld on skip", 64'(n_rv - rv0), 64'd0);
            end else begin
                send_rom(VECS[k].rom);
                chk("R5 rom_id", rom_id, VECS[k].rom);
                chk("R5 one rom_vld", 64'(n_rv - rv0), 64'd1);
            end
            send_byte(VECS[k].fn);
            chk("R8 fn_cmd", 64'(fn_cmd), 64'(VECS[k].fn));
            chk("R8 fn_unsup", 64'(fn_unsup), 64'(VECS[k].unsup));
            chk("R8 one fn_vld", 64'(n_fv - fv0), 64'd1);
            chk("R6 rom_vld count unchanged by function byte", 64'(n_rv - rv0),
                (VECS[k].typ == 3'd4 || VECS[k].typ == 3'd6) ? 64'd0 : 64'd1);
        end

        // R5: rom_vld is raised exactly in the cycle after the 64th bit.
        bus_reset();
        send_byte(8'h55);
        for (int i = 0; i < 63; i++) send_bit(1'b1);
        chk("R5 no early rom_vld", 64'(rom_vld), 64'd0);
        send_bit(1'b0);
        chk("R5 rom_vld after 64th bit", 64'(rom_vld), 64'd1);
        chk("R5 rom_id with last bit", rom_id, 64'h7FFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        chk("R5 rom_vld one cycle", 64'(rom_vld), 64'd0);

        // R9: unknown command sets a sticky error and blocks everything.
        bus_reset();
        rv0 = n_rv;
        fv0 = n_fv;
        sv = {56'd0, fn_cmd};
        send_byte(8'hA7);
        chk("R9 rom_err set", 64'(rom_err), 64'd1);
        chk("R9 rom_type unknown", 64'(rom_type), 64'd7);
        for (int i = 0; i < 72; i++) send_bit(1'b1);
        chk("R9 rom_err held", 64'(rom_err), 64'd1);
        chk("R9 no rom_vld", 64'(n_rv - rv0), 64'd0);
        chk("R9 no fn_vld", 64'(n_fv - fv0), 64'd0);
        chk("R9 fn_cmd unchanged", 64'(fn_cmd), sv);
        chk("R9 rom_cmd unchanged", 64'(rom_cmd), 64'hA7);

        // R2: a bus reset clears the error and the class.
        bus_reset();
        chk("R2 rom_err cleared", 64'(rom_err), 64'd0);
        chk("R2 rom_type cleared", 64'(rom_type), 64'd0);

        // R2: abort in the middle of an identifier, then restart cleanly.
        send_byte(8'h33);
        for (int i = 0; i < 30; i++) send_bit(1'b1);
        bus_reset();
        send_byte(8'hCC);
        chk("R2 new command after abort", 64'(rom_cmd), 64'hCC);
        chk("R2 skip class after abort", 64'(rom_type), 64'd4);
        send_byte(8'h4E);
        chk("R2 fn_cmd after abort", 64'(fn_cmd), 64'h4E);
        chk("R2 fn_unsup after abort", 64'(fn_unsup), 64'd0);

        // R7: search collision at position 5.
        bus_reset();
        sv = 64'hF0E1_D2C3_B4A5_9687;
        send_byte(8'hF0);
        send_search(sv, 5);
        chk("R7 collision true bits", srch_true, sv & ~(64'd1 << 5));
        chk("R7 collision cmpl bits", srch_cmpl, ~sv & ~(64'd1 << 5));
        chk("R7 rom_id with collision", rom_id, sv);

        // R10: bits after the function command are ignored.
        fv0 = n_fv;
        send_byte(8'hBE);
        chk("R10 fn_cmd captured", 64'(fn_cmd), 64'hBE);
        send_byte(8'hFF);
        send_byte(8'h00);
        chk("R10 fn_cmd held", 64'(fn_cmd), 64'hBE);
        chk("R10 rom_cmd held", 64'(rom_cmd), 64'hF0);
        chk("R10 single fn_vld", 64'(n_fv - fv0), 64'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule